// File: doc/BRIEF.md
# Systolic Cascaded FIR Filter

This block is a fully parallel finite impulse response filter with 32 taps. Each tap is an identical multiply-add stage: it multiplies a delayed copy of the input sample by its own fixed coefficient and adds the product to a partial sum handed over, through a register, by the stage before it. No adder tree is used. The sum leaving the final stage is the filter output. Because every stage is registered, the filter takes a new sample and produces a new result on every clock.

Each stage delays the sample by two registers before passing it on. This lines each product up with the partial sum that arrives from upstream, so the sample skew is built into the datapath and no separate delay line is needed. The coefficients are fixed when the block is built and are supplied as a parameter array. Entry 0 weights the newest sample. Every register in the block, including the valid pipeline, uses a synchronous reset.

The block is used as a streaming datapath element. Samples arrive with a valid flag. A cycle in which the flag is low enters the pipeline as a zero sample. Results leave with a valid flag delayed by the fixed pipeline depth.

Top module: `sys_fir`

## Requirements
- R1: The output is the exact sum over k = 0..31 of COEF[k]·x[n−k], as a 48-bit two's complement value, with no rounding and no saturation.
- R2: Samples are 25-bit signed and coefficients are 18-bit signed. They come from the parameter array COEF, and COEF[0] weights the newest sample.
- R3: One sample is accepted and one result is produced on every clock, so an unbroken run of valid inputs yields an unbroken run of valid outputs.
- R4: `out_valid` repeats `in_valid` delayed by exactly TAPS+3 = 35 clock edges, counting the edge that captures the input.
- R5: In a cycle with `in_valid` low, `in_sample` is ignored and the pipeline takes a zero sample in its place.
- R6: While `rst` is high at a clock edge, every register is cleared. From the reset edge until TAPS+3 edges after reset is released, `out_valid` is 0 and `out_data` is 0.
- R7: No operand combination overflows. With samples at −2^24 or 2^24−1 and coefficients at −2^17 or 2^17−1, the result is still exact.
- R8: Partial sums pass through one register in each stage, and the sample reaching stage k+1 is the sample seen by stage k two clocks earlier.
- R9: Reset is synchronous. Raising `rst` between clock edges leaves `out_valid` and `out_data` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample qualifier; low means a zero sample |
| in_sample | input | 25 | Signed input sample |
| out_valid | output | 1 | Result qualifier |
| out_data | output | 48 | Signed filter result |

## Verification
A single-sample impulse reads the coefficient set back out in tap order. This separates a correct systolic skew from a reversed or misaligned one, and it also shows which coefficient meets the newest sample. A long constant step builds the running coefficient sums and shows whether the cascade drops or repeats a stage. Random samples check general exactness. Patterns with gaps in the valid flag, carrying garbage on the invalid cycles, show whether those samples are truly replaced by zero. Alternating full-scale samples test the 48-bit headroom. A reset applied in the middle of a stream shows both that it does not act between edges and that the pipeline stays quiet until it has refilled. A lone valid pulse after an idle period gives the exact latency.

// File: rtl/fir_pkg.sv
`timescale 1ns/1ps
package fir_pkg;

    localparam int TAPS_DEFAULT = 32;
    localparam int SAMPLE_W     = 25;
    localparam int COEF_W       = 18;
    localparam int SUM_W        = 48;

    // input register + first sample delay + product register, plus one sum register per tap
    function automatic int pipe_depth(input int taps);
        return taps + 3;
    endfunction

endpackage

// File: rtl/fir_tap.sv
`timescale 1ns/1ps
module fir_tap #(
    parameter int XW = fir_pkg::SAMPLE_W,
    parameter int CW = fir_pkg::COEF_W,
    parameter int SW = fir_pkg::SUM_W,
    parameter logic signed [CW-1:0] COEF = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [XW-1:0] x_in,
    input  logic signed [SW-1:0] psum_in,
    output logic signed [XW-1:0] x_out,
    output logic signed [SW-1:0] psum_out
);

    localparam int PW = XW + CW;

    logic signed [XW-1:0] x_d1;
    logic signed [XW-1:0] x_d2;
    logic signed [PW-1:0] prod_q;
    logic signed [SW-1:0] psum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_d1   <= '0;
            x_d2   <= '0;
            prod_q <= '0;
            psum_q <= '0;
        end else begin
            x_d1   <= x_in;
            x_d2   <= x_d1;
            prod_q <= PW'(x_d1) * PW'(COEF);
            psum_q <= SW'(prod_q) + psum_in;
        end
    end

    assign x_out    = x_d2;
    assign psum_out = psum_q;

    AST_PROD_SIGN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(x_d1) != '0) && (COEF != '0))
        |-> (prod_q[PW-1] == ($past(x_d1[XW-1]) ^ COEF[CW-1]))); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(prod_q[PW-1]) == $past(psum_in[SW-1])))
        |-> (psum_q[SW-1] == $past(psum_in[SW-1]))); // R7

endmodule

// File: rtl/fir_valid_line.sv
`timescale 1ns/1ps
module fir_valid_line #(
    parameter int DEPTH = 35
) (
    input  logic clk,
    input  logic rst,
    input  logic vin,
    output logic vout
);

    logic [DEPTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[DEPTH-2:0], vin};
        end
    end

    assign vout = stage_q[DEPTH-1];

endmodule

// File: rtl/sys_fir.sv
`timescale 1ns/1ps
module sys_fir #(
    parameter int TAPS = fir_pkg::TAPS_DEFAULT,
    parameter int XW   = fir_pkg::SAMPLE_W,
    parameter int CW   = fir_pkg::COEF_W,
    parameter int SW   = fir_pkg::SUM_W,
    parameter logic signed [CW-1:0] COEF [TAPS] = '{default: CW'(1)}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [XW-1:0] in_sample,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_data
);

    localparam int LAT   = fir_pkg::pipe_depth(TAPS);
    localparam int CNT_W = $clog2(LAT + 1);

    logic signed [XW-1:0] x_link [TAPS+1];
    logic signed [SW-1:0] s_link [TAPS+1];
    logic signed [XW-1:0] x_in_q;

    // invalid cycles become zero samples
    always_ff @(posedge clk) begin
        if (rst) begin
            x_in_q <= '0;
        end else begin
            x_in_q <= in_valid ? in_sample : '0;
        end
    end

    assign x_link[0] = x_in_q;
    assign s_link[0] = '0;

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        fir_tap #(
            .XW   (XW),
            .CW   (CW),
            .SW   (SW),
            .COEF (COEF[g])
        ) u_tap (
            .clk      (clk),
            .rst      (rst),
            .x_in     (x_link[g]),
            .psum_in  (s_link[g]),
            .x_out    (x_link[g+1]),
            .psum_out (s_link[g+1])
        );
    end

    fir_valid_line #(
        .DEPTH (LAT)
    ) u_vld (
        .clk  (clk),
        .rst  (rst),
        .vin  (in_valid),
        .vout (out_valid)
    );

    assign out_data = s_link[TAPS];

    // cycles since reset, saturating; used only by the checks below
    logic [CNT_W-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst < CNT_W'(LAT)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    AST_REFILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CNT_W'(LAT)) |-> (!out_valid && (out_data == '0))); // R6

    for (genvar k = 0; k < TAPS; k++) begin : g_skew
        AST_SAMPLE_SKEW: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= CNT_W'(2)) |-> (x_link[k+1] == $past(x_link[k], 2))); // R8
    end

endmodule

// File: tb/sys_fir_bench.sv
`timescale 1ns/1ps
module sys_fir_bench;

    localparam int TAPS = 32;
    localparam int XW   = 25;
    localparam int CW   = 18;
    localparam int SW   = 48;
    localparam int LAT  = TAPS + 3;

    typedef logic signed [CW-1:0] coef_set_t [TAPS];

    function automatic coef_set_t make_coefs();
        coef_set_t c;
        for (int k = 0; k < TAPS; k++) begin
            c[k] = CW'(((k * 40503 + 12345) % 262144) - 131072);
        end
        c[0]      = -18'sd131072;
        c[TAPS-1] = 18'sd131071;
        return c;
    endfunction

    localparam coef_set_t BC = make_coefs();

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [XW-1:0] in_sample = '0;
    logic                 out_valid;
    logic signed [SW-1:0] out_data;

    int     checks = 0;
    int     failures = 0;
    int     n = 0;
    int     base = 0;
    bit     done = 1'b0;
    longint xs [0:4095];
    bit     vs [0:4095];
    logic signed [XW-1:0] rs;

    always #2.5 clk = ~clk;

    sys_fir #(
        .TAPS (TAPS), .XW (XW), .CW (CW), .SW (SW), .COEF (BC)
    ) u_sys_fir (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check_out(input string req);
        int     head;
        longint exp_d;
        bit     exp_v;
        head  = (n - 1) - (LAT - 1);
        exp_d = 0;
        exp_v = 1'b0;
        if (head >= base) begin
            exp_v = vs[head];
            for (int j = 0; j < TAPS; j++) begin
                if (head - j >= base) exp_d += longint'(BC[j]) * xs[head - j];
            end
        end
        checks += 2;
        if (out_valid !== exp_v) begin
            failures++;
            $display("FAIL %s out_valid actual=%0d expected=%0d edge=%0d", req, out_valid, exp_v, n - 1);
        end
        if (longint'(out_data) !== exp_d) begin
            failures++;
            $display("FAIL %s out_data actual=%0d expected=%0d edge=%0d", req, out_data, exp_d, n - 1);
        end
    endtask

    task automatic step(input bit r, input bit v, input longint x, input string req);
        rst       = r;
        in_valid  = v;
        in_sample = XW'(x);
        @(posedge clk);
        xs[n] = (r || !v) ? 0 : longint'(in_sample);
        vs[n] = !r && v;
        if (r) base = n + 1;
        n++;
        #1;
        check_out(req);
    endtask

    initial begin
        bit              pv;
        logic [SW-1:0]   pd;
        int              cnt;

        // R6: reset state
        repeat (3) step(1'b1, 1'b0, 0, "R6");

        // impulse: coefficients emerge in tap order (R2, R8)
        step(1'b0, 1'b1, 1, "R2");
        repeat (45) step(1'b0, 1'b1, 0, "R2/R8");

        // step input: running coefficient sums (R1)
        repeat (60) step(1'b0, 1'b1, 1000, "R1");

        // random continuous stream (R3)
        for (int i = 0; i < 300; i++) begin
            rs = XW'($urandom);
            step(1'b0, 1'b1, longint'(rs), "R3");
        end

        // reset raised between edges has no effect yet (R9)
        pv  = out_valid;
        pd  = out_data;
        rst = 1'b1;
        #1;
        checks++;
        if (out_valid !== pv || out_data !== pd) begin
            failures++;
            $display("FAIL R9 outputs changed before edge actual=%0d/%0d expected=%0d/%0d",
                     out_valid, out_data, pv, $signed(pd));
        end
        repeat (2) step(1'b1, 1'b1, 5, "R6");
        for (int i = 0; i < 50; i++) begin
            rs = XW'($urandom);
            step(1'b0, 1'b1, longint'(rs), "R6");
        end

        // gaps with garbage on invalid cycles (R5)
        for (int i = 0; i < 120; i++) begin
            rs = XW'($urandom);
            step(1'b0, (i % 3) != 1, longint'(rs), "R5");
        end

        // full-scale alternating samples (R7)
        for (int i = 0; i < 80; i++) begin
            step(1'b0, 1'b1, (i % 2) ? 64'sd16777215 : -64'sd16777216, "R7");
        end
        for (int i = 0; i < 40; i++) begin
            step(1'b0, 1'b1, ((i / 3) % 2) ? -64'sd16777216 : 64'sd16777215, "R7");
        end

        // exact latency of a lone valid pulse (R4)
        repeat (40) step(1'b0, 1'b0, 7, "R4");
        step(1'b0, 1'b1, 123, "R4");
        cnt = 0;
        while (!out_valid && cnt < 60) begin
            step(1'b0, 1'b0, 0, "R4");
            cnt++;
        end
        checks++;
        if (cnt + 1 != LAT) begin
            failures++;
            $display("FAIL R4 latency actual=%0d expected=%0d", cnt + 1, LAT);
        end
        repeat (5) step(1'b0, 1'b0, 0, "R4");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule